// File: doc/BRIEF.md
# Precise exception control unit

This block decides, cycle by cycle, whether a five-stage in-order pipeline must abandon its current work to service a fault. Two fault sources feed it: the decode stage reports an opcode it cannot recognise, and the execute stage reports a signed arithmetic overflow. Each report arrives with a valid qualifier and with the address of the instruction concerned.

When at least one qualified fault is present, the unit picks the one belonging to the oldest instruction. It squashes that instruction and everything fetched after it by clearing the control fields of the affected pipeline registers, and it steers fetch to a handler. The handler address is either one fixed entry point or a per-cause slot in a vector table, chosen by a mode input. On the following clock edge, the unit captures a return address and a one-bit cause code for software. Instructions older than the faulting one are left to retire normally.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `epc` reads 0, `cause` reads 0, `redirect` is low and `flush_regs` is all zero.
- R2: A qualified undefined-opcode report (`id_valid` and `id_undef`), with no qualified overflow in the same cycle, raises `redirect` in that same cycle and sets `flush_regs` to 3'b011 (bit 0 clears the fetch/decode register, bit 1 clears the decode/execute register). On the next rising edge, `cause` becomes 0 and `epc` becomes `id_pc + 4`, computed modulo 2^32.
- R3: A qualified overflow report (`ex_valid` and `ex_ovf`) raises `redirect` and sets `flush_regs` to 3'b111 in that cycle. Bit 2 clears the execute/memory register, so the faulting instruction never writes its destination. On the next edge, `cause` becomes 1 and `epc` becomes `ex_pc + 4`.
- R4: When both reports are qualified in one cycle, the overflow wins because its instruction is older. Outputs follow R3 and the decode report is dropped.
- R5: With `vec_mode` = 0, `redirect_pc` is 0x80000180 whenever `redirect` is high.
- R6: With `vec_mode` = 1, `redirect_pc` is 0xC0000000 + 0x20 × cause code of the accepted fault: 0xC0000000 for an undefined opcode and 0xC0000020 for overflow.
- R7: In any cycle with no qualified report, `epc` and `cause` keep their values across the next edge.
- R8: A report whose valid qualifier is low has no effect. In a cycle with no qualified report, `redirect` is 0, `flush_regs` is 0 and `redirect_pc` is 0. `redirect` and the flush bits are therefore high only in cycles that carry an accepted fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_mode | input | 1 | 0: single fixed handler; 1: per-cause vector slots |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_undef | input | 1 | Decode found an unrecognised opcode |
| id_pc | input | 32 | Address of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_ovf | input | 1 | Execute produced an arithmetic overflow |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| redirect | output | 1 | Fetch must load `redirect_pc` this cycle |
| redirect_pc | output | 32 | Handler entry address |
| flush_regs | output | 3 | Clear controls: bit0 fetch/decode, bit1 decode/execute, bit2 execute/memory |
| epc | output | 32 | Saved return address (faulting PC + 4) |
| cause | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
The assertions assume that the fault flags and PCs are stable and defined around each rising edge, and that a flag only matters together with its valid bit. The stage addresses are treated as arbitrary 32-bit values, so wrap-around at the top of the address space is legal. The bench changes every input only on the falling edge. It drives flags both with and without their qualifiers, and it uses a PC of 0xFFFFFFFC to exercise the return-address wrap.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // One-bit fault code; the value orders the vector slots.
  typedef enum logic [0:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int N_FLUSH = 3,
  localparam int REACH_W = $clog2(N_FLUSH)
) (
  input  logic               id_hit,
  input  logic [PC_W-1:0]    id_pc,
  input  logic               ex_hit,
  input  logic [PC_W-1:0]    ex_pc,
  output logic               take,
  output cause_e             win_cause,
  output logic [PC_W-1:0]    win_pc,
  output logic [REACH_W-1:0] win_reach
);
  // Highest pipeline-register index cleared for each source.
  localparam logic [REACH_W-1:0] ID_REACH = REACH_W'(N_FLUSH - 2);
  localparam logic [REACH_W-1:0] EX_REACH = REACH_W'(N_FLUSH - 1);

  always_comb begin
    take      = id_hit | ex_hit;
    win_cause = CAUSE_UNDEF;
    win_pc    = id_pc;
    win_reach = ID_REACH;
    if (ex_hit) begin
      // Execute holds the older instruction.
      win_cause = CAUSE_OVF;
      win_pc    = ex_pc;
      win_reach = EX_REACH;
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] FIXED_ENTRY = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE    = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE  = 32'h0000_0020
) (
  input  logic            take,
  input  logic            vec_mode,
  input  cause_e          cause_in,
  output logic [PC_W-1:0] target
);
  function automatic logic [PC_W-1:0] entry_of(input logic vm, input cause_e c);
    logic [PC_W-1:0] slot;
    slot = PC_W'(c) * VEC_STRIDE;
    return vm ? (VEC_BASE + slot) : FIXED_ENTRY;
  endfunction

  assign target = take ? entry_of(vec_mode, cause_in) : '0;
endmodule

// File: rtl/exc_record.sv
module exc_record
  import exc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  cause_e          cause_in,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] epc_q,
  output cause_e          cause_q
);
  function automatic logic [PC_W-1:0] return_addr(input logic [PC_W-1:0] pc);
    return pc + PC_W'(INSN_BYTES);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CAUSE_UNDEF;
    end else if (take) begin
      epc_q   <= return_addr(pc_in);
      cause_q <= cause_in;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter int              N_FLUSH     = 3,
  parameter int              INSN_BYTES  = 4,
  parameter logic [PC_W-1:0] FIXED_ENTRY = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE    = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE  = 32'h0000_0020
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vec_mode,
  input  logic               id_valid,
  input  logic               id_undef,
  input  logic [PC_W-1:0]    id_pc,
  input  logic               ex_valid,
  input  logic               ex_ovf,
  input  logic [PC_W-1:0]    ex_pc,
  output logic               redirect,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [N_FLUSH-1:0] flush_regs,
  output logic [PC_W-1:0]    epc,
  output logic               cause
);
  localparam int REACH_W = $clog2(N_FLUSH);

  // Named internal events, visible to the bound checker.
  logic               id_hit_w, ex_hit_w, take_w;
  cause_e             win_cause_w, cause_q_w;
  logic [PC_W-1:0]    win_pc_w;
  logic [REACH_W-1:0] win_reach_w;

  assign id_hit_w = id_valid & id_undef;
  assign ex_hit_w = ex_valid & ex_ovf;

  exc_arbiter #(.PC_W(PC_W), .N_FLUSH(N_FLUSH)) u_arb (
    .id_hit    (id_hit_w),
    .id_pc     (id_pc),
    .ex_hit    (ex_hit_w),
    .ex_pc     (ex_pc),
    .take      (take_w),
    .win_cause (win_cause_w),
    .win_pc    (win_pc_w),
    .win_reach (win_reach_w)
  );

  exc_vector #(
    .PC_W(PC_W), .FIXED_ENTRY(FIXED_ENTRY),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_vec (
    .take     (take_w),
    .vec_mode (vec_mode),
    .cause_in (win_cause_w),
    .target   (redirect_pc)
  );

  exc_record #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_w),
    .cause_in (win_cause_w),
    .pc_in    (win_pc_w),
    .epc_q    (epc),
    .cause_q  (cause_q_w)
  );

  // Clear every pipeline register from fetch/decode up to the winner's reach.
  for (genvar k = 0; k < N_FLUSH; k++) begin : g_flush
    assign flush_regs[k] = take_w && (REACH_W'(k) <= win_reach_w);
  end

  assign redirect = take_w;
  assign cause    = cause_q_w;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int PC_W    = 32,
  parameter int N_FLUSH = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vec_mode,
  input logic               id_valid,
  input logic               id_undef,
  input logic [PC_W-1:0]    id_pc,
  input logic               ex_valid,
  input logic               ex_ovf,
  input logic [PC_W-1:0]    ex_pc,
  input logic               redirect,
  input logic [PC_W-1:0]    redirect_pc,
  input logic [N_FLUSH-1:0] flush_regs,
  input logic [PC_W-1:0]    epc,
  input logic               cause,
  input logic               take_w
);
  logic ovf_q, und_q;
  assign ovf_q = ex_valid && ex_ovf;
  assign und_q = id_valid && id_undef;

  AST_UNDEF_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    und_q && !ovf_q |=> !cause && epc == $past(id_pc) + 32'd4); // R2
  AST_UNDEF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    und_q && !ovf_q |-> redirect && flush_regs == 3'b011); // R2
  AST_OVF_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> cause && epc == $past(ex_pc) + 32'd4); // R3
  AST_OVF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> redirect && flush_regs == 3'b111); // R4
  AST_FIXED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && !vec_mode |-> redirect_pc == 32'h8000_0180); // R5
  AST_VEC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && vec_mode |-> redirect_pc == (ovf_q ? 32'hC000_0020 : 32'hC000_0000)); // R6
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> $stable(epc) && $stable(cause)); // R7
  AST_QUIET_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_q && !und_q |-> !redirect && flush_regs == '0 && redirect_pc == '0); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> epc == '0 && !cause); // R1
endmodule

bind exc_ctrl exc_ctrl_chk #(.PC_W(PC_W), .N_FLUSH(N_FLUSH)) u_chk (.*);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_mode = 1'b0;
  logic        id_valid = 1'b0, id_undef = 1'b0, ex_valid = 1'b0, ex_ovf = 1'b0;
  logic [31:0] id_pc = '0, ex_pc = '0;
  logic        redirect;
  logic [31:0] redirect_pc, epc;
  logic [2:0]  flush_regs;
  logic        cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .redirect(redirect), .redirect_pc(redirect_pc), .flush_regs(flush_regs),
    .epc(epc), .cause(cause)
  );

  typedef struct packed {
    logic        vm;
    logic        iv;
    logic        iu;
    logic [31:0] ipc;
    logic        ev;
    logic        eo;
    logic [31:0] xpc;
    logic        x_redir;
    logic [2:0]  x_flush;
    logic [31:0] x_target;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b1, 1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'h0,           1'b1, 3'b011, 32'h8000_0180}, // R2 R5
    '{1'b0, 1'b0, 1'b0, 32'h0000_0200, 1'b1, 1'b1, 32'h0000_0400,   1'b1, 3'b111, 32'h8000_0180}, // R3 R5
    '{1'b1, 1'b1, 1'b1, 32'h0000_0600, 1'b1, 1'b1, 32'h0000_05FC,   1'b1, 3'b111, 32'hC000_0020}, // R4 R6
    '{1'b1, 1'b1, 1'b1, 32'h0000_0700, 1'b0, 1'b0, 32'h0,           1'b1, 3'b011, 32'hC000_0000}, // R6
    '{1'b1, 1'b0, 1'b1, 32'h0000_0800, 1'b0, 1'b1, 32'h0000_0900,   1'b0, 3'b000, 32'h0},         // R8
    '{1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0,           1'b0, 3'b000, 32'h0},         // R7
    '{1'b0, 1'b1, 1'b0, 32'h0000_0A00, 1'b1, 1'b0, 32'h0000_0B00,   1'b0, 3'b000, 32'h0},         // R7
    '{1'b0, 1'b1, 1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0,           1'b1, 3'b011, 32'h8000_0180}  // R2 wrap
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    vec_mode = r.vm; id_valid = r.iv; id_undef = r.iu; id_pc = r.ipc;
    ex_valid = r.ev; ex_ovf = r.eo; ex_pc = r.xpc;
  endtask

  logic [31:0] m_epc;
  logic        m_cause;

  initial begin
    m_epc = '0; m_cause = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 epc in reset", epc, 32'h0);
    chk("R1 cause in reset", {31'b0, cause}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 redirect after reset", {31'b0, redirect}, 32'h0);
    chk("R1 flush after reset", {29'b0, flush_regs}, 32'h0);
    chk("R1 epc after reset", epc, 32'h0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      drive(ROWS[i]);
      #1;
      chk("R2/R3/R8 redirect", {31'b0, redirect}, {31'b0, ROWS[i].x_redir});
      chk("R2/R3/R4 flush_regs", {29'b0, flush_regs}, {29'b0, ROWS[i].x_flush});
      chk("R5/R6 redirect_pc", redirect_pc, ROWS[i].x_target);
      // Bench model of the saved state (R2 R3 R4 R7)
      if (ROWS[i].ev && ROWS[i].eo) begin
        m_epc = ROWS[i].xpc + 32'd4; m_cause = 1'b1;
      end else if (ROWS[i].iv && ROWS[i].iu) begin
        m_epc = ROWS[i].ipc + 32'd4; m_cause = 1'b0;
      end
      @(posedge clk);
      #1;
      chk("R2/R3/R4/R7 epc", epc, m_epc);
      chk("R2/R3/R4/R7 cause", {31'b0, cause}, {31'b0, m_cause});
    end

    // R7: a long idle stretch keeps the saved state.
    @(negedge clk);
    id_valid = 1'b0; ex_valid = 1'b0; id_undef = 1'b1; ex_ovf = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 epc idle hold", epc, 32'h0000_0000);
    chk("R8 redirect with unqualified flags", {31'b0, redirect}, 32'h0);

    // R4: overflow beats undefined opcode; two faults in back-to-back cycles.
    vec_mode = 1'b1; id_valid = 1'b1; id_undef = 1'b1; id_pc = 32'h0000_1004;
    ex_valid = 1'b1; ex_ovf = 1'b1; ex_pc = 32'h0000_1000;
    @(negedge clk);
    chk("R4 cause ovf wins", {31'b0, cause}, 32'h1);
    chk("R4 epc from execute pc", epc, 32'h0000_1004);
    ex_valid = 1'b0;
    #1;
    chk("R6 undef vector slot", redirect_pc, 32'hC000_0000);
    @(negedge clk);
    chk("R2 cause undef next", {31'b0, cause}, 32'h0);
    chk("R2 epc undef next", epc, 32'h0000_1008);

    // R1: reset in the middle of operation clears saved state.
    id_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 async clear epc", epc, 32'h0);
    chk("R1 async clear cause", {31'b0, cause}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule